// File: doc/BRIEF.md
# Settable 24-Hour Time Counter

This block holds the time of day as three binary fields (seconds, minutes and hours) and advances them by one second each time a slow tick input rises. The tick is sampled on the system clock. Every field register changes only in the clock cycle in which a rising tick is seen, so the whole block runs on one clock and advances on a qualified enable. The three fields go straight out to a display.

Seconds can be cleared to zero by a dedicated control. Minutes and hours are set from one shared value bus, each by its own load strobe. Hours take only the low bits of that bus. Loads and clears take effect on the same tick that would otherwise increment the field. Loaded values are not range-checked. A field wraps to zero only on an exact match with its last legal value.

Top module: `hms_counter`

## Requirements
- R1: A low `rst_n` sampled on a clock edge sets seconds, minutes and hours to 0 and forgets any tick history. Reset has priority over every other input.
- R2: The fields change only on the clock edge at which `tick` is sampled 1 after having been sampled 0 (or after reset). The new values are visible after that edge. A tick held high for many cycles advances the time once.
- R3: On each advance, seconds go up by 1. When seconds were 59 before the advance, they go to 0 instead.
- R4: Minutes go up by 1 only on an advance where the previous seconds were 59. When minutes were also 59, they go to 0 instead.
- R5: Hours go up by 1 only on an advance where the previous minutes and seconds were both 59. When hours were 23, they go to 0 instead.
- R6: When `clr_sec` is 1 on an advance, seconds become 0. The carry into minutes is still decided by the previous seconds value.
- R7: When `ld_min` is 1 on an advance, minutes take `ld_val` instead of incrementing. The carry into hours is still decided by the previous minutes and seconds.
- R8: When `ld_hr` is 1 on an advance, hours take `ld_val[4:0]` (bit 5 is dropped) instead of incrementing.
- R9: A loaded value outside the legal range is stored unchanged and then increments modulo 2^width (64 for minutes, 32 for hours). The field wraps to 0 only on an exact match with 59 or 23, or on the natural overflow of its width.
- R10: Seconds never exceed 59.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Slow time base; each rising level advances one second |
| clr_sec | input | 1 | Clear seconds on the next advance |
| ld_min | input | 1 | Load minutes from `ld_val` on the next advance |
| ld_hr | input | 1 | Load hours from `ld_val[4:0]` on the next advance |
| ld_val | input | 6 | Shared load value for minutes and hours |
| sec_o | output | 6 | Seconds, binary |
| min_o | output | 6 | Minutes, binary |
| hr_o | output | 5 | Hours, binary |

## Verification
The bench goes after the two cascaded carries:
- At 59:59, a block that tested the updated seconds instead of the previous seconds would skip or double the hour step.
- At 23:59:59 the hours must return to zero; a block that wrapped late would show 24.

It also checks that a load or clear does not swallow the carry. Clearing seconds while they read 59 must still move the minutes, and loading minutes at 59:59 must still move the hours.

Loads are swept over every value of the bus. Out-of-range minutes and hours are run forward to show that they count up to their width limit and overflow to zero rather than stick. A tick held high is checked to advance the time only once.

// File: rtl/hms_pkg.sv
// Shared constants for the time-of-day counter.
// Assumes a 24-hour day with 60-second minutes and 60-minute hours.
package hms_pkg;
    localparam int SEC_BITS  = 6;
    localparam int MIN_BITS  = 6;
    localparam int HR_BITS   = 5;
    localparam int SEC_TOP   = 59;
    localparam int MIN_TOP   = 59;
    localparam int HR_TOP    = 23;
endpackage

// File: rtl/rise_detect.sv
// Rising-level detector for a slow input sampled on the system clock.
// Assumes the input is already synchronous to clk. The pulse lasts one cycle.
module rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic din_q;

    // Remember the previous sample; reset forgets history.
    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= 1'b0;
        else        din_q <= din;
    end

    assign rise = din & ~din_q;
endmodule

// File: rtl/wrap_field.sv
// One time field: loads, or steps and wraps on an exact match with TOP.
// Assumes the caller qualifies adv with the tick edge. A load wins over a step.
// at_top reports the current value equal to TOP, for the carry into the next field.
module wrap_field #(
    parameter int W   = 6,
    parameter int TOP = 59
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q,
    output logic         at_top
);
    localparam logic [W-1:0] TOP_V = W'(TOP);

    assign at_top = (q == TOP_V);

    // Field register: reset, load, or step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (adv) begin
            if (load)      q <= load_val;
            else if (step) q <= at_top ? '0 : q + 1'b1;
        end
    end
endmodule

// File: rtl/hms_counter.sv
// Settable 24-hour counter of hours, minutes and seconds.
// Assumes tick is synchronous to clk and far slower than it.
// Carries between fields use the values from before the advance.
module hms_counter
    import hms_pkg::*;
#(
    parameter int SEC_W  = SEC_BITS,
    parameter int MIN_W  = MIN_BITS,
    parameter int HR_W   = HR_BITS,
    parameter int SEC_LT = SEC_TOP,
    parameter int MIN_LT = MIN_TOP,
    parameter int HR_LT  = HR_TOP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr_sec,
    input  logic             ld_min,
    input  logic             ld_hr,
    input  logic [MIN_W-1:0] ld_val,
    output logic [SEC_W-1:0] sec_o,
    output logic [MIN_W-1:0] min_o,
    output logic [HR_W-1:0]  hr_o
);
    logic adv;
    logic sec_top, min_top, hr_top;

    rise_detect u_edge (
        .clk (clk),
        .rst_n (rst_n),
        .din (tick),
        .rise (adv)
    );

    wrap_field #(.W(SEC_W), .TOP(SEC_LT)) u_sec (
        .clk (clk), .rst_n (rst_n), .adv (adv),
        .step (1'b1), .load (clr_sec), .load_val ('0),
        .q (sec_o), .at_top (sec_top)
    );

    wrap_field #(.W(MIN_W), .TOP(MIN_LT)) u_min (
        .clk (clk), .rst_n (rst_n), .adv (adv),
        .step (sec_top), .load (ld_min), .load_val (ld_val),
        .q (min_o), .at_top (min_top)
    );

    wrap_field #(.W(HR_W), .TOP(HR_LT)) u_hr (
        .clk (clk), .rst_n (rst_n), .adv (adv),
        .step (sec_top & min_top), .load (ld_hr), .load_val (ld_val[HR_W-1:0]),
        .q (hr_o), .at_top (hr_top)
    );

    // The hour equality output is not needed above the hours field.
    logic unused_ok;
    assign unused_ok = hr_top;
endmodule

// File: rtl/hms_counter_checker.sv
// Property checker for hms_counter, bound to every instance.
// Keeps its own record of the tick level so that advances are seen from the ports.
module hms_counter_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       clr_sec,
    input logic       ld_min,
    input logic       ld_hr,
    input logic [5:0] ld_val,
    input logic [5:0] sec_o,
    input logic [5:0] min_o,
    input logic [4:0] hr_o
);
    logic tick_seen;

    // Tick level at the previous edge, as observed by the checker.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_seen <= 1'b0;
        else        tick_seen <= tick;
    end

    logic go;
    assign go = tick & ~tick_seen;

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (sec_o == 6'd0 && min_o == 6'd0 && hr_o == 5'd0));

    assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && rst_n) |=> ($stable(sec_o) && $stable(min_o) && $stable(hr_o)));

    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && sec_o == 6'd59) |=> sec_o == 6'd0);

    assert_min_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (go && sec_o == 6'd59 && min_o == 6'd20 && !ld_min) |=> min_o == 6'd21);

    assert_hr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (go && sec_o == 6'd59 && min_o == 6'd59 && hr_o == 5'd23 && !ld_hr) |=> hr_o == 5'd0);

    assert_sec_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (go && clr_sec) |=> sec_o == 6'd0);

    assert_min_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (go && ld_min) |=> min_o == $past(ld_val));

    assert_hr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && ld_hr) |=> hr_o == $past(ld_val[4:0]));

    assert_sec_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sec_o <= 6'd59);
endmodule

bind hms_counter hms_counter_checker u_chk (.*);

// File: tb/tb_hms_counter.sv
// Self-checking bench for hms_counter: sweeps and an arithmetic reference model.
module tb_hms_counter;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       clr_sec = 1'b0, ld_min = 1'b0, ld_hr = 1'b0;
    logic [5:0] ld_val = '0;
    logic [5:0] sec_o, min_o;
    logic [4:0] hr_o;

    int n_cmp = 0, n_bad = 0;
    int e_sec = 0, e_min = 0, e_hr = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hms_counter dut (
        .clk (clk), .rst_n (rst_n), .tick (tick),
        .clr_sec (clr_sec), .ld_min (ld_min), .ld_hr (ld_hr), .ld_val (ld_val),
        .sec_o (sec_o), .min_o (min_o), .hr_o (hr_o)
    );

    // Compare all three fields against the model.
    task automatic check(input string tag);
        n_cmp++;
        if (sec_o != 6'(e_sec) || min_o != 6'(e_min) || hr_o != 5'(e_hr)) begin
            n_bad++;
            $display("FAIL %s: got %0d:%0d:%0d expected %0d:%0d:%0d",
                     tag, hr_o, min_o, sec_o, e_hr, e_min, e_sec);
        end
    endtask

    // Reference advance, using the values from before the advance for every carry.
    task automatic model_adv(input bit c, input bit sm, input bit sh, input int v);
        bit sc, mc;
        sc = (e_sec == 59);
        mc = sc && (e_min == 59);
        e_sec = c ? 0 : (sc ? 0 : (e_sec + 1) % 64);
        if (sm)      e_min = v % 64;
        else if (sc) e_min = (e_min == 59) ? 0 : (e_min + 1) % 64;
        if (sh)      e_hr = v % 32;
        else if (mc) e_hr = (e_hr == 23) ? 0 : (e_hr + 1) % 32;
    endtask

    // One tick pulse with optional controls, then a compare.
    task automatic pulse(input bit c, input bit sm, input bit sh, input int v, input string tag);
        @(negedge clk);
        tick = 1; clr_sec = c; ld_min = sm; ld_hr = sh; ld_val = 6'(v);
        model_adv(c, sm, sh, v);
        @(negedge clk);
        tick = 0; clr_sec = 0; ld_min = 0; ld_hr = 0;
        check(tag);
    endtask

    task automatic run_to_sec59(input string tag);
        while (e_sec != 59) pulse(0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1 reset state");

        // R2: idle cycles without a tick change nothing.
        repeat (4) @(negedge clk);
        check("R2 idle");
        // R2: tick held high advances once.
        @(negedge clk); tick = 1; model_adv(0, 0, 0, 0);
        repeat (6) @(negedge clk);
        check("R2 held tick");
        tick = 0;
        repeat (3) @(negedge clk);
        check("R2 after release");

        // R3 R4 R5: plain count through more than one hour.
        for (int i = 0; i < 3700; i++) pulse(0, 0, 0, 0, "R3 R4 R5 count");

        // R5: across midnight.
        pulse(0, 1, 1, 23, "R8 set hour 23");
        pulse(0, 1, 0, 59, "R7 set minute 59");
        for (int i = 0; i < 130; i++) pulse(0, 0, 0, 0, "R5 midnight");

        // R6: clear while seconds read 59 still moves minutes.
        run_to_sec59("R3 approach");
        pulse(1, 0, 0, 0, "R6 clear with carry");
        pulse(0, 0, 0, 0, "R3 after clear");
        pulse(1, 0, 0, 0, "R6 clear mid-minute");

        // R7: load minutes at 59:59 still carries into hours.
        pulse(0, 1, 1, 5, "R7 R8 set 05:05");
        pulse(0, 1, 0, 59, "R7 set 59");
        run_to_sec59("R3 approach");
        pulse(0, 1, 0, 7, "R7 load keeps hour carry");

        // R7 R8: every bus value into minutes and into hours.
        for (int v = 0; v < 64; v++) pulse(0, 1, 0, v, "R7 load sweep");
        for (int v = 0; v < 64; v++) pulse(0, 0, 1, v, "R8 R9 load sweep");

        // R9: out-of-range minutes count to overflow.
        pulse(0, 1, 0, 62, "R9 minutes 62");
        for (int i = 0; i < 200; i++) pulse(0, 0, 0, 0, "R9 minutes overflow");
        // R9: out-of-range hours count to overflow.
        pulse(0, 1, 1, 31, "R9 hours 31");
        pulse(0, 1, 0, 59, "R9 minutes 59");
        run_to_sec59("R3 approach");
        pulse(0, 0, 0, 0, "R9 hours overflow to 0");
        pulse(0, 1, 1, 26, "R9 hours 26");
        pulse(0, 1, 0, 59, "R9 minutes 59");
        run_to_sec59("R3 approach");
        pulse(0, 0, 0, 0, "R9 hours 26 to 27");

        // R1: reset in mid-run wins over a tick.
        @(negedge clk); rst_n = 0; tick = 1;
        e_sec = 0; e_min = 0; e_hr = 0;
        @(negedge clk); check("R1 reset over tick");
        rst_n = 1; tick = 0;
        @(negedge clk); check("R1 after reset");
        pulse(0, 0, 0, 0, "R3 first second");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule